// File: doc/BRIEF.md
# DAC Command Byte Decoder

This block sits behind an I2C slave front end. It turns three-byte write frames into updates of a 16-bit DAC code and a power-down mode. The front end hands over each received byte with a strobe and the byte's position in the frame. It also marks the start and the stop of each frame, and it pulses `ack_done` when the acknowledge that follows a byte has finished.

The first byte is a control byte. Its load field (bits [5:4]) selects one of four actions: stage the data in a temporary entry, stage and load the DAC at once, load the DAC from the staged entry, or broadcast-load. For a broadcast load, bit 2 selects the source: the staged entry or the bytes just received. When bit 0 is set, the frame carries a power-down request, and bits [7:5] of the most significant data byte hold the mode code.

Every register change waits for the acknowledge pulse that follows the least significant byte. Frames that end early, arrive out of order or set a reserved bit leave the block untouched.

The sequencer `dac_frame_fsm` has six named states:
- S_IDLE: waiting for a frame.
- S_CTRL: expecting the control byte.
- S_MSB: expecting the most significant data byte.
- S_LSB: expecting the least significant data byte.
- S_ACK: waiting for the final acknowledge.
- S_DROP: the frame is discarded.

It has these transitions:
- start: any state goes to S_CTRL.
- stop: any state goes to S_IDLE.
- in-order byte: S_CTRL goes to S_MSB, S_MSB goes to S_LSB, and S_LSB goes to S_ACK.
- wrong index, or an extra byte while in S_ACK: the state goes to S_DROP.
- commit: S_ACK goes to S_IDLE when the acknowledge arrives.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After reset, `dac_code` is 0, `pd_mode` is 0 and `pd_active` is 0. The staged entry holds data 0 with no power-down request.
- R2: Load field 00 writes the staged entry (data {MSB,LSB}, or a power-down request when control bit 0 is 1). It leaves `dac_code` and `pd_mode` unchanged.
- R3: Load field 01 writes the staged entry and also loads the DAC with the received value.
- R4: Load field 10 loads the DAC from the staged entry. The two data bytes of that frame are ignored and do not alter the staged entry.
- R5: Load field 11 is a broadcast load. With control bit 2 = 0, the source is the staged entry. With control bit 2 = 1, the source is the received bytes. In both cases the staged entry is not written.
- R6: Control bits [7:6] have no effect in any mode. In particular, they do not block a broadcast load.
- R7: Control bit 0 = 1 marks a power-down request whose mode code is MSB bits [7:5]. Loading such a request sets `pd_mode` to that code and keeps `dac_code`. Loading plain data sets `dac_code` and clears `pd_mode`. `pd_active` is 1 exactly when `pd_mode` is not zero.
- R8: Outputs change only in the cycle after an `ack_done` pulse that arrives in the acknowledge-wait state after the least significant byte.
- R9: A frame that stops before its final acknowledge changes no register.
- R10: A frame with control bit 3 or bit 1 set, or with bit 2 set while the load field is not 11, changes no register.
- R11: Byte indices must arrive as 0 (control), 1 (MSB), 2 (LSB). Any other order discards the frame. A new `frame_start` restarts collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: a write frame begins |
| frame_stop | input | 1 | Pulse: the frame ends |
| byte_valid | input | 1 | Pulse: `byte_data` holds a received byte |
| byte_idx | input | 2 | Position of the byte in the frame |
| byte_data | input | 8 | Received byte |
| ack_done | input | 1 | Pulse: an acknowledge has completed |
| dac_code | output | 16 | Active DAC code |
| pd_mode | output | 3 | Active power-down mode code |
| pd_active | output | 1 | Power-down in effect |

## Verification
The assertions assume that every strobe (`frame_start`, `frame_stop`, `byte_valid` and `ack_done`) is a single-cycle pulse. They also assume that the front end never raises `byte_valid` and `ack_done` in the same cycle. The stimulus drives each strobe for exactly one clock on its own, and it places the acknowledge one cycle after the last byte. Early stops, wrong byte orders and reserved control patterns are driven as deliberate frames, but they still keep to this one-strobe-per-cycle rule.

// File: rtl/dac_dec_pkg.sv
package dac_dec_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 2;
    localparam int MODE_W = 3;

    localparam int C_PD    = 0;
    localparam int C_RSV1  = 1;
    localparam int C_BSRC  = 2;
    localparam int C_RSV3  = 3;
    localparam int C_LD_LO = 4;
    localparam int C_LD_HI = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_CTRL, S_MSB, S_LSB, S_ACK, S_DROP
    } frame_state_t;

    typedef enum logic [1:0] {
        LD_STAGE  = 2'b00,
        LD_DIRECT = 2'b01,
        LD_STAGED = 2'b10,
        LD_BCAST  = 2'b11
    } load_kind_t;
endpackage

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_dec_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          frame_stop,
    input  logic          byte_valid,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [BW-1:0] byte_data,
    input  logic          ack_done,
    output logic [BW-1:0] ctrl_q,
    output logic [BW-1:0] msb_q,
    output logic [BW-1:0] lsb_q,
    output logic          frame_done
);
    frame_state_t state, state_nx;
    logic         take;

    assign take = byte_valid && !frame_start && !frame_stop;

    always_comb begin
        state_nx = state;
        if (frame_start) begin
            state_nx = S_CTRL;
        end else if (frame_stop) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: state_nx = S_IDLE;
                S_CTRL: if (byte_valid) state_nx = (byte_idx == 2'd0) ? S_MSB : S_DROP;
                S_MSB:  if (byte_valid) state_nx = (byte_idx == 2'd1) ? S_LSB : S_DROP;
                S_LSB:  if (byte_valid) state_nx = (byte_idx == 2'd2) ? S_ACK : S_DROP;
                S_ACK: begin
                    if (byte_valid)    state_nx = S_DROP;
                    else if (ack_done) state_nx = S_IDLE;
                end
                S_DROP: state_nx = S_DROP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        frame_done = (state == S_ACK) && ack_done && !byte_valid
                     && !frame_start && !frame_stop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            msb_q  <= '0;
            lsb_q  <= '0;
        end else if (take) begin
            if (state == S_CTRL && byte_idx == 2'd0) ctrl_q <= byte_data;
            if (state == S_MSB  && byte_idx == 2'd1) msb_q  <= byte_data;
            if (state == S_LSB  && byte_idx == 2'd2) lsb_q  <= byte_data;
        end
    end

    // R11: a dropped frame never reaches the acknowledge-wait state without a new start
    a_r11_drop_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP && !frame_start) |=> (state == S_DROP || state == S_IDLE));

    // R8: a completed frame returns the sequencer to idle
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> state == S_IDLE);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_dec_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int MW = MODE_W
) (
    input  logic [BW-1:0]   ctrl,
    input  logic [BW-1:0]   msb,
    input  logic [BW-1:0]   lsb,
    output logic            legal,
    output logic            wr_stage,
    output logic            do_load,
    output logic            src_stage,
    output logic            new_pd,
    output logic [MW-1:0]   new_mode,
    output logic [2*BW-1:0] new_data
);
    load_kind_t kind;

    always_comb begin
        kind     = load_kind_t'(ctrl[C_LD_HI:C_LD_LO]);
        legal    = !ctrl[C_RSV3] && !ctrl[C_RSV1]
                   && !(ctrl[C_BSRC] && kind != LD_BCAST);
        new_pd   = ctrl[C_PD];
        new_mode = msb[BW-1 -: MW];
        new_data = {msb, lsb};
        wr_stage  = 1'b0;
        do_load   = 1'b0;
        src_stage = 1'b0;
        unique case (kind)
            LD_STAGE:  wr_stage = 1'b1;
            LD_DIRECT: begin wr_stage = 1'b1; do_load = 1'b1; end
            LD_STAGED: begin do_load = 1'b1; src_stage = 1'b1; end
            LD_BCAST:  begin do_load = 1'b1; src_stage = !ctrl[C_BSRC]; end
        endcase
    end
endmodule

// File: rtl/dac_regs.sv
module dac_regs
    import dac_dec_pkg::*;
#(
    parameter int DW = 2*BYTE_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          wr_stage,
    input  logic          do_load,
    input  logic          src_stage,
    input  logic          new_pd,
    input  logic [MW-1:0] new_mode,
    input  logic [DW-1:0] new_data,
    output logic [DW-1:0] dac_code,
    output logic [MW-1:0] pd_mode
);
    logic          stg_pd;
    logic [MW-1:0] stg_mode;
    logic [DW-1:0] stg_data;

    logic          sel_pd;
    logic [MW-1:0] sel_mode;
    logic [DW-1:0] sel_data;

    always_comb begin
        sel_pd   = src_stage ? stg_pd   : new_pd;
        sel_mode = src_stage ? stg_mode : new_mode;
        sel_data = src_stage ? stg_data : new_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_pd   <= 1'b0;
            stg_mode <= '0;
            stg_data <= '0;
        end else if (commit && wr_stage) begin
            stg_pd   <= new_pd;
            stg_mode <= new_mode;
            stg_data <= new_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
            pd_mode  <= '0;
        end else if (commit && do_load) begin
            if (sel_pd) begin
                pd_mode <= sel_mode;
            end else begin
                dac_code <= sel_data;
                pd_mode  <= '0;
            end
        end
    end

    // R8: outputs hold between commits
    a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(dac_code) && $stable(pd_mode)));

    // R2: a staging-only commit leaves the outputs alone
    a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !do_load) |=> ($stable(dac_code) && $stable(pd_mode)));

    // R4: loading staged plain data copies the staged word
    a_r4_staged_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && do_load && src_stage && !stg_pd)
        |=> (dac_code == $past(stg_data) && pd_mode == '0));

    // R7: a loaded power-down request keeps the code
    a_r7_pd_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && do_load && sel_pd) |=> $stable(dac_code));
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
    import dac_dec_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int MW = MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_stop,
    input  logic              byte_valid,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BW-1:0]     byte_data,
    input  logic              ack_done,
    output logic [2*BW-1:0]   dac_code,
    output logic [MW-1:0]     pd_mode,
    output logic              pd_active
);
    localparam int DW = 2 * BW;

    logic [BW-1:0] ctrl_q, msb_q, lsb_q;
    logic          frame_done, legal, commit;
    logic          wr_stage, do_load, src_stage, new_pd;
    logic [MW-1:0] new_mode;
    logic [DW-1:0] new_data;

    dac_frame_fsm #(.BW(BW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_stop(frame_stop),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .ack_done(ack_done),
        .ctrl_q(ctrl_q), .msb_q(msb_q), .lsb_q(lsb_q),
        .frame_done(frame_done)
    );

    dac_cmd_decode #(.BW(BW), .MW(MW)) u_dec (
        .ctrl(ctrl_q), .msb(msb_q), .lsb(lsb_q),
        .legal(legal), .wr_stage(wr_stage), .do_load(do_load),
        .src_stage(src_stage), .new_pd(new_pd),
        .new_mode(new_mode), .new_data(new_data)
    );

    assign commit = frame_done && legal;

    dac_regs #(.DW(DW), .MW(MW)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .wr_stage(wr_stage), .do_load(do_load), .src_stage(src_stage),
        .new_pd(new_pd), .new_mode(new_mode), .new_data(new_data),
        .dac_code(dac_code), .pd_mode(pd_mode)
    );

    assign pd_active = |pd_mode;

    // R10: a completed frame with reserved bits set changes nothing
    a_r10_reserved_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !legal) |=> ($stable(dac_code) && $stable(pd_mode)));

    // R9: a stop pulse never updates the outputs
    a_r9_stop_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stop |=> ($stable(dac_code) && $stable(pd_mode)));
endmodule

// File: tb/test_dac_cmd_decoder.sv
`timescale 1ns/1ps
module test_dac_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, frame_stop = 1'b0;
    logic        byte_valid = 1'b0, ack_done = 1'b0;
    logic [1:0]  byte_idx = '0;
    logic [7:0]  byte_data = '0;
    logic [15:0] dac_code;
    logic [2:0]  pd_mode;
    logic        pd_active;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dac_cmd_decoder i_dac_cmd_decoder (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_stop(frame_stop),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .ack_done(ack_done),
        .dac_code(dac_code), .pd_mode(pd_mode), .pd_active(pd_active)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [15:0] code,
                           input logic [2:0] mode);
        chk({tag, " code"}, dac_code, code);
        chk({tag, " mode"}, {13'd0, pd_mode}, {13'd0, mode});
        chk({tag, " active"}, {15'd0, pd_active}, {15'd0, (mode != 3'd0)});
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); frame_stop = 1'b1; @(negedge clk); frame_stop = 1'b0;
    endtask
    task automatic pulse_ack();
        @(negedge clk); ack_done = 1'b1; @(negedge clk); ack_done = 1'b0;
    endtask
    task automatic put_byte(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_idx = idx; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] m, input logic [7:0] l);
        pulse_start();
        put_byte(2'd0, c); put_byte(2'd1, m); put_byte(2'd2, l);
        pulse_ack();
        pulse_stop();
    endtask

    task automatic t_reset();
        chk_out("R1 reset", 16'h0000, 3'd0);
        frame(8'h20, 8'hFF, 8'hFF);           // staged entry after reset is zero data
        chk_out("R1 staged zero", 16'h0000, 3'd0);
    endtask

    task automatic t_direct_and_stage();
        frame(8'h10, 8'hAB, 8'hCD);
        chk_out("R3 direct load", 16'hABCD, 3'd0);
        frame(8'h00, 8'h12, 8'h34);
        chk_out("R2 stage only", 16'hABCD, 3'd0);
        frame(8'h20, 8'hFF, 8'hFF);
        chk_out("R4 load staged", 16'h1234, 3'd0);
        frame(8'h10, 8'h00, 8'h01);
        frame(8'h20, 8'h99, 8'h99);           // R3: direct load also staged 0001
        chk_out("R3 staged copy", 16'h0001, 3'd0);
    endtask

    task automatic t_ack_timing();
        pulse_start();
        put_byte(2'd0, 8'h10); put_byte(2'd1, 8'h77); put_byte(2'd2, 8'h88);
        chk_out("R8 before ack", 16'h0001, 3'd0);
        @(negedge clk); ack_done = 1'b1;
        @(negedge clk); ack_done = 1'b0;
        chk_out("R8 after ack", 16'h7788, 3'd0);
        pulse_ack();                          // stray ack after commit
        pulse_stop();
        chk_out("R8 stray ack", 16'h7788, 3'd0);
    endtask

    task automatic t_broadcast();
        frame(8'h00, 8'h55, 8'h55);
        frame(8'hF0, 8'h99, 8'h99);
        chk_out("R5 R6 bcast staged", 16'h5555, 3'd0);
        frame(8'h34, 8'h77, 8'h77);
        chk_out("R5 bcast data", 16'h7777, 3'd0);
        frame(8'hF4, 8'h66, 8'h66);
        chk_out("R6 bcast data hi bits", 16'h6666, 3'd0);
        frame(8'h20, 8'h00, 8'h00);
        chk_out("R5 staged untouched", 16'h5555, 3'd0);
    endtask

    task automatic t_powerdown();
        frame(8'h11, 8'hA0, 8'h00);
        chk_out("R7 pd direct", 16'h5555, 3'd5);
        frame(8'h10, 8'h11, 8'h11);
        chk_out("R7 data clears pd", 16'h1111, 3'd0);
        frame(8'h01, 8'h60, 8'h00);
        chk_out("R2 R7 pd staged only", 16'h1111, 3'd0);
        frame(8'h20, 8'h00, 8'h00);
        chk_out("R7 pd from stage", 16'h1111, 3'd3);
        frame(8'h35, 8'h00, 8'h00);
        chk_out("R7 pd mode zero", 16'h1111, 3'd0);
        frame(8'h10, 8'h22, 8'h22);
        chk_out("R7 restore", 16'h2222, 3'd0);
    endtask

    task automatic t_early_stop();
        pulse_start();
        put_byte(2'd0, 8'h10); put_byte(2'd1, 8'h33); put_byte(2'd2, 8'h33);
        pulse_stop();
        pulse_ack();
        chk_out("R9 stop before ack", 16'h2222, 3'd0);
        pulse_start();
        put_byte(2'd0, 8'h10); put_byte(2'd1, 8'h44);
        pulse_stop();
        chk_out("R9 two bytes", 16'h2222, 3'd0);
    endtask

    task automatic t_reserved();
        frame(8'h18, 8'h33, 8'h33);
        chk_out("R10 bit3", 16'h2222, 3'd0);
        frame(8'h12, 8'h33, 8'h33);
        chk_out("R10 bit1", 16'h2222, 3'd0);
        frame(8'h14, 8'h33, 8'h33);
        chk_out("R10 bit2 non-bcast", 16'h2222, 3'd0);
    endtask

    task automatic t_order();
        pulse_start();
        put_byte(2'd0, 8'h10); put_byte(2'd2, 8'h33); put_byte(2'd1, 8'h33);
        pulse_ack();
        pulse_stop();
        chk_out("R11 wrong order", 16'h2222, 3'd0);
        pulse_start();
        put_byte(2'd0, 8'h10); put_byte(2'd1, 8'h44);
        frame(8'h10, 8'h56, 8'h56);
        chk_out("R11 restart", 16'h5656, 3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_and_stage();
        t_ack_timing();
        t_broadcast();
        t_powerdown();
        t_early_stop();
        t_reserved();
        t_order();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule